// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Target Cache

This block predicts the direction and destination of branches at fetch time. A direct-mapped table of two-bit saturating state machines, indexed by the low-order bits of the instruction address just above the instruction alignment bits, gives the taken or not-taken prediction. Unrelated branches that share an index also share a state machine.

A small fully associative cache holds the targets of branches currently predicted taken. Each entry is tagged with the full branch address. Both structures are read combinationally in the same cycle as the fetch address arrives. On a cache hit the stored target is the next fetch address.

A resolve port takes each executed branch's address, its actual outcome and its actual target, and steps the matching state machine. The target cache does not change on every taken branch. An entry is created only when a state machine crosses from weakly not-taken to weakly taken. It is dropped only when the state machine crosses back from weakly taken to weakly not-taken.

Top module: `branch_pred_unit`

## Requirements
- R1: While rst_ni is low and after it rises, every history state is strongly not-taken and every target-cache entry is invalid, so every lookup returns hit 0 and taken 0.
- R2: History state is encoded 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken, 11 strongly taken. A taken resolve moves it one step toward 11, a not-taken resolve one step toward 00, and it saturates at both ends.
- R3: The history index is address bits [OFS_W+IDX_W-1:OFS_W]. Two addresses with equal index bits share one state machine.
- R4: A resolve that moves a state from 01 to 10 writes the branch address and actual target into the target cache. A lookup of that address then returns hit 1 and that target.
- R5: A resolve that moves a state from 10 to 01 invalidates the cache entry whose tag equals the resolved address, if one exists.
- R6: No other state transition changes the target cache.
- R7: A lookup that misses returns hit 0 and a target of all zeros. lk_taken_o is bit 1 of the indexed history state.
- R8: An allocation takes the lowest-numbered invalid entry. When all entries are valid, it takes the entry named by a round-robin pointer that starts at 0 and advances by one, wrapping, on each such allocation.
- R9: A lookup in the same cycle as a resolve to the same index returns the state and cache contents from before that resolve.
- R10: An allocation for an address already held in the cache rewrites that entry's target, so at most one entry ever matches an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_pc_i | input | ADDR_W | Fetch address to predict |
| lk_hit_o | output | 1 | Target cache holds this address |
| lk_target_o | output | ADDR_W | Predicted target, zero on a miss |
| lk_taken_o | output | 1 | History prediction, 1 means taken |
| upd_valid_i | input | 1 | A resolved branch is presented |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 means taken |
| upd_target_i | input | ADDR_W | Actual target of the resolved branch |

## Verification
The bench builds the block with a 16-entry history table, a 4-entry target cache, 16-bit addresses and two offset bits. With these values two addresses 64 bytes apart alias to one state machine, so cross-branch interference on allocation and removal can be driven directly. The cache fills after four allocations, so lowest-free placement, round-robin eviction and a freed slot taking priority over the pointer are all reached within a few dozen resolves.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    ST_SNT = 2'b00,
    ST_WNT = 2'b01,
    ST_WT  = 2'b10,
    ST_ST  = 2'b11
  } bp_state_e;

  function automatic bp_state_e bp_step(bp_state_e cur, logic taken);
    bp_state_e nxt;
    nxt = cur;
    if (taken && cur != ST_ST)       nxt = bp_state_e'(cur + 2'd1);
    else if (!taken && cur != ST_SNT) nxt = bp_state_e'(cur - 2'd1);
    return nxt;
  endfunction
endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table
  import bp_pkg::*;
#(
  parameter int ENTRIES = 512,
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_pc_i,
  output bp_state_e         rd_state_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_pc_i,
  input  logic              wr_taken_i,
  output bp_state_e         wr_old_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  bp_state_e state_q [ENTRIES];
  logic [IDX_W-1:0] rd_idx, wr_idx;

  assign rd_idx     = rd_pc_i[OFS_W +: IDX_W];
  assign wr_idx     = wr_pc_i[OFS_W +: IDX_W];
  assign rd_state_o = state_q[rd_idx];
  assign wr_old_o   = state_q[wr_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) state_q[i] <= ST_SNT;
    end else if (wr_en_i) begin
      state_q[wr_idx] <= bp_step(state_q[wr_idx], wr_taken_i);
    end
  end
endmodule

// File: rtl/bp_target_cache.sv
module bp_target_cache #(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  lk_pc_i,
  output logic               lk_hit_o,
  output logic [ADDR_W-1:0]  lk_target_o,
  output logic [ENTRIES-1:0] lk_match_o,
  input  logic [ADDR_W-1:0]  upd_pc_i,
  input  logic [ADDR_W-1:0]  upd_target_i,
  input  logic               alloc_i,
  input  logic               remove_i,
  output logic               upd_hit_o,
  output logic [ENTRIES-1:0] valid_o
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, upd_match;
  logic [PTR_W-1:0]   rr_q, free_idx, hit_idx, victim;
  logic               full;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match_o[g] = valid_q[g] && (tag_q[g] == lk_pc_i);
    assign upd_match[g]  = valid_q[g] && (tag_q[g] == upd_pc_i);
  end

  assign lk_hit_o  = |lk_match_o;
  assign upd_hit_o = |upd_match;
  assign full      = &valid_q;
  assign valid_o   = valid_q;

  always_comb begin
    lk_target_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match_o[i]) lk_target_o = lk_target_o | tgt_q[i];
  end

  // lowest free slot and matching slot
  always_comb begin
    free_idx = '0;
    hit_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i])  free_idx = PTR_W'(i);
      if (upd_match[i]) hit_idx  = PTR_W'(i);
    end
    if (upd_hit_o)  victim = hit_idx;
    else if (!full) victim = free_idx;
    else            victim = rr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (alloc_i) begin
      valid_q[victim] <= 1'b1;
      if (full && !upd_hit_o) rr_q <= (rr_q == PTR_LAST) ? '0 : rr_q + 1'b1;
    end else if (remove_i) begin
      valid_q <= valid_q & ~upd_match;
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i) begin
      tag_q[victim] <= upd_pc_i;
      tgt_q[victim] <= upd_target_i;
    end
  end
endmodule

// File: rtl/branch_pred_unit.sv
module branch_pred_unit
  import bp_pkg::*;
#(
  parameter int HIST_ENTRIES = 512,
  parameter int TGT_ENTRIES  = 64,
  parameter int ADDR_W       = 32,
  parameter int OFS_W        = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              lk_hit_o,
  output logic [ADDR_W-1:0] lk_target_o,
  output logic              lk_taken_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i
);
  bp_state_e            lk_state, upd_old;
  logic                 alloc_evt, rm_evt, upd_hit;
  logic [TGT_ENTRIES-1:0] tc_valid, lk_match;

  bp_hist_table #(
    .ENTRIES(HIST_ENTRIES), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
  ) u_hist (
    .clk_i, .rst_ni,
    .rd_pc_i    (lk_pc_i),
    .rd_state_o (lk_state),
    .wr_en_i    (upd_valid_i),
    .wr_pc_i    (upd_pc_i),
    .wr_taken_i (upd_taken_i),
    .wr_old_o   (upd_old)
  );

  // cache changes only on the crossings between the two weak states
  assign alloc_evt = upd_valid_i &&  upd_taken_i && (upd_old == ST_WNT);
  assign rm_evt    = upd_valid_i && !upd_taken_i && (upd_old == ST_WT);

  bp_target_cache #(
    .ENTRIES(TGT_ENTRIES), .ADDR_W(ADDR_W)
  ) u_tc (
    .clk_i, .rst_ni,
    .lk_pc_i      (lk_pc_i),
    .lk_hit_o     (lk_hit_o),
    .lk_target_o  (lk_target_o),
    .lk_match_o   (lk_match),
    .upd_pc_i     (upd_pc_i),
    .upd_target_i (upd_target_i),
    .alloc_i      (alloc_evt),
    .remove_i     (rm_evt),
    .upd_hit_o    (upd_hit),
    .valid_o      (tc_valid)
  );

  assign lk_taken_o = lk_state[1];
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int TGT_ENTRIES = 64,
  parameter int ADDR_W      = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   lk_hit_o,
  input logic [ADDR_W-1:0]      lk_target_o,
  input logic                   alloc_evt,
  input logic                   rm_evt,
  input logic                   upd_hit,
  input logic [TGT_ENTRIES-1:0] tc_valid,
  input logic [TGT_ENTRIES-1:0] lk_match
);
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> lk_target_o == '0); // R7

  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match)); // R10

  AST_ALLOC_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_evt && !upd_hit && !(&tc_valid) |=>
      $countones(tc_valid) == $past($countones(tc_valid)) + 1); // R4

  AST_ALLOC_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_evt && (upd_hit || (&tc_valid)) |=> $stable(tc_valid)); // R8

  AST_REMOVE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rm_evt && upd_hit |=>
      $countones(tc_valid) == $past($countones(tc_valid)) - 1); // R5

  AST_QUIET_CACHE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_evt && !rm_evt |=> $stable(tc_valid)); // R6
endmodule

bind branch_pred_unit bp_checker #(
  .TGT_ENTRIES(TGT_ENTRIES), .ADDR_W(ADDR_W)
) u_bp_chk (.*);

// File: tb/branch_pred_unit_test.sv
`timescale 1ns/1ps
module branch_pred_unit_test;
  localparam int AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] lk_pc_i = '0;
  logic          lk_hit_o, lk_taken_o;
  logic [AW-1:0] lk_target_o;
  logic          upd_valid_i = 1'b0;
  logic [AW-1:0] upd_pc_i = '0;
  logic          upd_taken_i = 1'b0;
  logic [AW-1:0] upd_target_i = '0;

  int n_chk = 0;
  int n_bad = 0;

  branch_pred_unit #(
    .HIST_ENTRIES(16), .TGT_ENTRIES(4), .ADDR_W(AW), .OFS_W(2)
  ) uut (.*);

  always #4 clk_i = ~clk_i;

  typedef struct packed {
    logic          uv;
    logic [AW-1:0] upc;
    logic          utk;
    logic [AW-1:0] utg;
    logic [AW-1:0] lpc;
    logic          eh;
    logic          et;
    logic [AW-1:0] etg;
  } vec_t;

  localparam logic [AW-1:0] PA = 16'h0104, PB = 16'h0144;
  localparam logic [AW-1:0] T1 = 16'h2000, T2 = 16'h3000, T3 = 16'h3400;

  // R2 R3 R4 R5 R6 R7: one history entry walked through every transition
  localparam vec_t VEC [11] = '{
    '{1'b1, PA, 1'b1, T1, PA, 1'b0, 1'b0, 16'h0},
    '{1'b1, PA, 1'b1, T1, PA, 1'b1, 1'b1, T1},
    '{1'b1, PA, 1'b1, T1, PA, 1'b1, 1'b1, T1},
    '{1'b1, PA, 1'b1, T1, PA, 1'b1, 1'b1, T1},
    '{1'b1, PA, 1'b0, T1, PA, 1'b1, 1'b1, T1},
    '{1'b1, PA, 1'b0, T1, PA, 1'b0, 1'b0, 16'h0},
    '{1'b1, PA, 1'b0, T1, PA, 1'b0, 1'b0, 16'h0},
    '{1'b1, PA, 1'b0, T1, PA, 1'b0, 1'b0, 16'h0},
    '{1'b1, PB, 1'b1, T2, PA, 1'b0, 1'b0, 16'h0},
    '{1'b1, PB, 1'b1, T2, PA, 1'b0, 1'b1, 16'h0},
    '{1'b0, PB, 1'b0, T2, PB, 1'b1, 1'b1, T2}
  };

  task automatic resolve(input logic [AW-1:0] pc, input logic tk, input logic [AW-1:0] tg);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = tk; upd_target_i = tg;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
  endtask

  task automatic check_lk(input logic [AW-1:0] pc, input logic eh, input logic et,
                          input logic [AW-1:0] etg, input string req);
    lk_pc_i = pc;
    #1;
    n_chk++;
    if (lk_hit_o !== eh || lk_taken_o !== et || lk_target_o !== etg) begin
      n_bad++;
      $display("FAIL %s pc=%h hit=%b exp %b taken=%b exp %b target=%h exp %h",
               req, pc, lk_hit_o, eh, lk_taken_o, et, lk_target_o, etg);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic alloc2(input logic [AW-1:0] pc, input logic [AW-1:0] tg);
    resolve(pc, 1'b1, tg);
    resolve(pc, 1'b1, tg);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: state during and after reset
    #2;
    check_lk(PA, 1'b0, 1'b0, 16'h0, "R1 in reset");
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    check_lk(16'h0000, 1'b0, 1'b0, 16'h0, "R1");
    check_lk(16'hFFFC, 1'b0, 1'b0, 16'h0, "R1");

    for (int k = 0; k < 11; k++) begin
      if (VEC[k].uv) resolve(VEC[k].upc, VEC[k].utk, VEC[k].utg);
      else @(negedge clk_i);
      check_lk(VEC[k].lpc, VEC[k].eh, VEC[k].et, VEC[k].etg, "R2/R3/R4/R5/R6 vector");
    end

    // R10: alias drops shared state to weak not-taken without removing PB
    resolve(PA, 1'b0, T1);
    check_lk(PB, 1'b1, 1'b0, T2, "R5 alias keeps entry");
    resolve(PB, 1'b1, T3);
    check_lk(PB, 1'b1, 1'b1, T3, "R10 rewrite target");
    resolve(PB, 1'b0, T3);
    check_lk(PB, 1'b0, 1'b0, 16'h0, "R10 single entry removed");

    // R1: mid-run reset clears state
    resolve(PB, 1'b1, T2);
    check_lk(PB, 1'b1, 1'b1, T2, "R4 before reset");
    do_reset();
    check_lk(PB, 1'b0, 1'b0, 16'h0, "R1 after reset");

    // R8: lowest free then round robin
    alloc2(16'h0010, 16'hA000);
    alloc2(16'h0020, 16'hA100);
    alloc2(16'h0030, 16'hA200);
    alloc2(16'h0040, 16'hA300);
    alloc2(16'h0014, 16'hA400);
    check_lk(16'h0010, 1'b0, 1'b1, 16'h0,   "R8 slot0 evicted");
    check_lk(16'h0020, 1'b1, 1'b1, 16'hA100, "R8");
    check_lk(16'h0014, 1'b1, 1'b1, 16'hA400, "R8");
    alloc2(16'h0018, 16'hA500);
    check_lk(16'h0020, 1'b0, 1'b1, 16'h0,   "R8 slot1 evicted");
    check_lk(16'h0030, 1'b1, 1'b1, 16'hA200, "R8");
    resolve(16'h0040, 1'b0, 16'h0);
    check_lk(16'h0040, 1'b0, 1'b0, 16'h0,   "R5");
    alloc2(16'h001C, 16'hA600);
    check_lk(16'h001C, 1'b1, 1'b1, 16'hA600, "R8 free slot used");
    check_lk(16'h0030, 1'b1, 1'b1, 16'hA200, "R8 pointer untouched");
    check_lk(16'h0018, 1'b1, 1'b1, 16'hA500, "R8");

    // R9: same-cycle lookup sees pre-update contents
    do_reset();
    resolve(PA, 1'b1, T1);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_pc_i = PA; upd_taken_i = 1'b1; upd_target_i = T1;
    check_lk(PA, 1'b0, 1'b0, 16'h0, "R9 same cycle");
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    check_lk(PA, 1'b1, 1'b1, T1, "R9 next cycle");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule